// File: doc/BRIEF.md
# Command-Driven Up/Down Count Comparator

This block is a signed event counter that sits on a shared command backplane. Direction pulses from a position transducer arrive on two lines, one for forward steps and one for reverse steps. The block brings them into the system clock domain and adds them into a two's-complement count register. A set of short commands controls the card: clear it, take a snapshot of the count, present the snapshot on the bus, or arm a load of a target value with a tolerance. Two self-test modes cut off the pulse lines and step the count at a fixed rate until it wraps.

Each card is given one of six slot codes. Addressed commands act only on the card whose slot code matches. Two broadcast commands, a system clear and a sample, act on every card together. A snapshot is never taken in a cycle where the count is changing, and a bus read waits until any pending snapshot has landed. A compare output goes high when the count has moved further from the loaded target than the tolerance allows.

Top module: `updn_cmd_comparator`

## Requirements
- R1: An addressed command (cmd_bcast=0) acts only when cmd_addr equals the card's slot code MY_ADDR. The valid slot codes are 0 to 5. Command codes 5, 6 and 8 to 15 do nothing.
- R2: Reset, or command code 0, sets the count to 160 (PRESET), clears the sticky wrap flag, ends any self-test and forces diff_out low. After reset, data_valid, diff_out and rd_count are all 0.
- R3: Command code 1 sets a snapshot pending. The count is copied into the snapshot buffer in the first cycle in which no count step takes place.
- R4: Command code 2 presents the buffer on rd_count, the sticky wrap flag on rd_ovfl, res_sel on rd_fine and a point code on rd_dp (DP_FINE when res_sel=1, DP_COARSE otherwise), and pulses data_valid for one cycle. This waits while a snapshot is pending.
- R5: Command code 3 arms a load. At the next rising edge of dav, dest_in and tol_in are stored as target and tolerance. A rising edge of dav while the load is not armed is ignored.
- R6: Command code 4 starts a downward self-test. The pulse lines are ignored and the count drops by one every TICK_DIV clocks, with the first step TICK_DIV clocks after the command. The test stops on the decrement that wraps from the most negative value to the most positive one.
- R7: Command code 7 starts an upward self-test. It steps at the same rate and stops on the increment that wraps from the most positive value to the most negative one.
- R8: Any wrap in either direction sets a sticky wrap flag. The flag stays set until reset or command code 0.
- R9: diff_out is high when |count − target| > tolerance. It stays low after reset or command code 0 until a target has been loaded.
- R10: up_in and dn_in pass through a synchronizer, and each rising edge counts as one step. Edges seen in the same cycle on both lines cancel. When the block is not in self-test, an up edge adds one and a down edge subtracts one.
- R11: With cmd_bcast=1, command code 0 acts as a system clear and code 1 as a sample on every card, whatever cmd_addr holds. All other broadcast codes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| up_in | input | 1 | Forward step pulses (asynchronous) |
| dn_in | input | 1 | Reverse step pulses (asynchronous) |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_bcast | input | 1 | 1 = broadcast command, 0 = addressed command |
| cmd_addr | input | 3 | Target slot code |
| cmd_code | input | 4 | Command code |
| dav | input | 1 | Data-available strobe for a target load |
| dest_in | input | CNT_W | Target value on the bus |
| tol_in | input | TOL_W | Tolerance value on the bus |
| res_sel | input | 1 | Resolution-mode flag reported on read |
| rd_count | output | CNT_W | Snapshot value presented by a read |
| rd_ovfl | output | 1 | Sticky wrap flag presented by a read |
| rd_fine | output | 1 | Resolution flag presented by a read |
| rd_dp | output | 4 | Decimal-point code presented by a read |
| data_valid | output | 1 | One-cycle strobe marking valid read data |
| diff_out | output | 1 | Outside-tolerance indication |

## Verification
The hardest case to reach from the ports is a snapshot that lands exactly on a count step, so that the capture has to slip by a cycle and a read issued just after it has to wait. The bench starts an upward self-test and sends the sample and read commands on the two clock cycles right after it. With TICK_DIV at 2, the sample's first chance to capture falls on a step cycle. The read must therefore return the count after that step and not the one before it. To reach both wrap ends in a few thousand cycles, the bench shrinks the count width to 12 bits.

// File: rtl/ucc_pkg.sv
package ucc_pkg;
  typedef enum logic [1:0] {SC_IDLE, SC_UP, SC_DN} sc_mode_t;

  localparam logic [3:0] OP_CLEAR  = 4'd0;
  localparam logic [3:0] OP_SAMPLE = 4'd1;
  localparam logic [3:0] OP_READ   = 4'd2;
  localparam logic [3:0] OP_LOAD   = 4'd3;
  localparam logic [3:0] OP_SC_DN  = 4'd4;
  localparam logic [3:0] OP_SC_UP  = 4'd7;

  localparam int NUM_SLOTS = 6;
endpackage

// File: rtl/ucc_sync_edge.sv
module ucc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ucc_cmd_decode.sv
module ucc_cmd_decode
  import ucc_pkg::*;
#(
  parameter logic [2:0] MY_ADDR = 3'd0
) (
  input  logic       cmd_valid,
  input  logic       cmd_bcast,
  input  logic [2:0] cmd_addr,
  input  logic [3:0] cmd_code,
  output logic       do_clear,
  output logic       do_sample,
  output logic       do_read,
  output logic       do_arm,
  output logic       do_up,
  output logic       do_dn
);
  logic mine, every;

  always_comb begin
    mine  = cmd_valid && !cmd_bcast && (cmd_addr == MY_ADDR) && (int'(MY_ADDR) < NUM_SLOTS);
    every = cmd_valid && cmd_bcast;
    do_clear  = (mine || every) && (cmd_code == OP_CLEAR);
    do_sample = (mine || every) && (cmd_code == OP_SAMPLE);
    do_read   = mine && (cmd_code == OP_READ);
    do_arm    = mine && (cmd_code == OP_LOAD);
    do_dn     = mine && (cmd_code == OP_SC_DN);
    do_up     = mine && (cmd_code == OP_SC_UP);
  end
endmodule

// File: rtl/ucc_count_core.sv
module ucc_count_core
  import ucc_pkg::*;
#(
  parameter int CNT_W    = 28,
  parameter int PRESET   = 160,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             go_up,
  input  logic             go_dn,
  input  logic             up_ev,
  input  logic             dn_ev,
  output logic [CNT_W-1:0] count,
  output logic             ovfl,
  output logic             step
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0]    TLAST = TW'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] MAXV  = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] MINV  = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] PVAL  = CNT_W'(PRESET);

  sc_mode_t     mode;
  logic [TW-1:0] tick;
  logic tick_hit, inc, dec, wrap;

  always_comb begin
    tick_hit = (mode != SC_IDLE) && (tick == TLAST);
    inc  = (mode == SC_UP && tick_hit) || (mode == SC_IDLE && up_ev && !dn_ev);
    dec  = (mode == SC_DN && tick_hit) || (mode == SC_IDLE && dn_ev && !up_ev);
    wrap = (inc && count == MAXV) || (dec && count == MINV);
    step = inc || dec;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= PVAL;
      mode  <= SC_IDLE;
      tick  <= '0;
      ovfl  <= 1'b0;
    end else begin
      if (inc)      count <= count + 1'b1;
      else if (dec) count <= count - 1'b1;
      if (wrap) ovfl <= 1'b1;
      if (go_up)      mode <= SC_UP;
      else if (go_dn) mode <= SC_DN;
      else if (wrap && mode != SC_IDLE) mode <= SC_IDLE;
      if (mode == SC_IDLE || go_up || go_dn) tick <= '0;
      else if (tick == TLAST)                tick <= '0;
      else                                   tick <= tick + 1'b1;
    end
  end

  a_r10_cancel: assert property (@(posedge clk) disable iff (rst)
    (mode == SC_IDLE && up_ev && dn_ev && !clr) |=> $stable(count));
  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (mode != SC_IDLE && tick != TLAST && !clr) |=> $stable(count));
  a_r8_sticky_wrap: assert property (@(posedge clk) disable iff (rst)
    (ovfl && !clr) |=> ovfl);
  a_r2_clear_preset: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == PVAL && !ovfl && mode == SC_IDLE));
endmodule

// File: rtl/updn_cmd_comparator.sv
module updn_cmd_comparator
  import ucc_pkg::*;
#(
  parameter int         CNT_W       = 28,
  parameter int         TOL_W       = 4,
  parameter int         PRESET      = 160,
  parameter int         TICK_DIV    = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] MY_ADDR     = 3'd0,
  parameter logic [3:0] DP_COARSE   = 4'd1,
  parameter logic [3:0] DP_FINE     = 4'd2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_in,
  input  logic             dn_in,
  input  logic             cmd_valid,
  input  logic             cmd_bcast,
  input  logic [2:0]       cmd_addr,
  input  logic [3:0]       cmd_code,
  input  logic             dav,
  input  logic [CNT_W-1:0] dest_in,
  input  logic [TOL_W-1:0] tol_in,
  input  logic             res_sel,
  output logic [CNT_W-1:0] rd_count,
  output logic             rd_ovfl,
  output logic             rd_fine,
  output logic [3:0]       rd_dp,
  output logic             data_valid,
  output logic             diff_out
);
  localparam int DW = CNT_W + 1;

  logic up_ev, dn_ev;
  logic do_clear, do_sample, do_read, do_arm, do_up, do_dn;
  logic [CNT_W-1:0] count, snap, dest;
  logic [TOL_W-1:0] tol;
  logic ovfl, step;
  logic smp_pend, rd_pend, armed, dest_valid, dav_q;
  logic signed [DW-1:0] delta;
  logic [DW-1:0] mag;
  logic outside;

  ucc_sync_edge #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst(rst), .din(up_in), .rise(up_ev));
  ucc_sync_edge #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .rst(rst), .din(dn_in), .rise(dn_ev));

  ucc_cmd_decode #(.MY_ADDR(MY_ADDR)) u_dec (
    .cmd_valid(cmd_valid), .cmd_bcast(cmd_bcast), .cmd_addr(cmd_addr),
    .cmd_code(cmd_code), .do_clear(do_clear), .do_sample(do_sample),
    .do_read(do_read), .do_arm(do_arm), .do_up(do_up), .do_dn(do_dn));

  ucc_count_core #(.CNT_W(CNT_W), .PRESET(PRESET), .TICK_DIV(TICK_DIV)) u_core (
    .clk(clk), .rst(rst), .clr(do_clear), .go_up(do_up), .go_dn(do_dn),
    .up_ev(up_ev), .dn_ev(dn_ev), .count(count), .ovfl(ovfl), .step(step));

  always_comb begin
    delta   = $signed({count[CNT_W-1], count}) - $signed({dest[CNT_W-1], dest});
    mag     = delta[DW-1] ? DW'(-delta) : DW'(delta);
    outside = mag > DW'(tol);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_pend   <= 1'b0;
      rd_pend    <= 1'b0;
      snap       <= '0;
      rd_count   <= '0;
      rd_ovfl    <= 1'b0;
      rd_fine    <= 1'b0;
      rd_dp      <= '0;
      data_valid <= 1'b0;
      armed      <= 1'b0;
      dest_valid <= 1'b0;
      dest       <= '0;
      tol        <= '0;
      dav_q      <= 1'b0;
      diff_out   <= 1'b0;
    end else begin
      dav_q <= dav;
      if (smp_pend && !step) begin
        snap     <= count;
        smp_pend <= 1'b0;
      end
      if (do_sample) smp_pend <= 1'b1;

      data_valid <= 1'b0;
      if (rd_pend && !smp_pend) begin
        rd_count   <= snap;
        rd_ovfl    <= ovfl;
        rd_fine    <= res_sel;
        rd_dp      <= res_sel ? DP_FINE : DP_COARSE;
        data_valid <= 1'b1;
        rd_pend    <= 1'b0;
      end
      if (do_read) rd_pend <= 1'b1;

      if (armed && dav && !dav_q) begin
        dest       <= dest_in;
        tol        <= tol_in;
        dest_valid <= 1'b1;
        armed      <= 1'b0;
      end
      if (do_arm)   armed      <= 1'b1;
      if (do_clear) dest_valid <= 1'b0;

      diff_out <= dest_valid && outside;
    end
  end

  a_r4_buffer_steady: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> $stable(snap));
  a_r9_null_until_loaded: assert property (@(posedge clk) disable iff (rst)
    !dest_valid |=> !diff_out);
  a_r3_no_capture_on_step: assert property (@(posedge clk) disable iff (rst)
    (smp_pend && step) |=> smp_pend);
endmodule

// File: tb/updn_cmd_comparator_tb.sv
module updn_cmd_comparator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam logic [2:0] ME = 3'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_in = 0, dn_in = 0, cmd_valid = 0, cmd_bcast = 0, dav = 0, res_sel = 0;
  logic [2:0] cmd_addr = '0;
  logic [3:0] cmd_code = '0;
  logic [CW-1:0] dest_in = '0;
  logic [3:0] tol_in = '0;
  logic [CW-1:0] rd_count;
  logic rd_ovfl, rd_fine, data_valid, diff_out;
  logic [3:0] rd_dp;

  int n_chk = 0, n_err = 0;
  logic [CW-1:0] g_cnt;
  logic g_ov, g_fine, g_got;
  logic [3:0] g_dp;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_cmd_comparator #(.CNT_W(CW), .TOL_W(4), .PRESET(160), .TICK_DIV(2),
    .SYNC_STAGES(2), .MY_ADDR(ME), .DP_COARSE(4'd1), .DP_FINE(4'd2)) dut_i (
    .clk(clk), .rst(rst), .up_in(up_in), .dn_in(dn_in), .cmd_valid(cmd_valid),
    .cmd_bcast(cmd_bcast), .cmd_addr(cmd_addr), .cmd_code(cmd_code), .dav(dav),
    .dest_in(dest_in), .tol_in(tol_in), .res_sel(res_sel), .rd_count(rd_count),
    .rd_ovfl(rd_ovfl), .rd_fine(rd_fine), .rd_dp(rd_dp), .data_valid(data_valid),
    .diff_out(diff_out));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; the command is valid for exactly one rising edge
  task automatic send(logic b, logic [2:0] a, logic [3:0] c);
    cmd_bcast = b; cmd_addr = a; cmd_code = c; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_dv();
    g_got = 1'b0;
    for (int i = 0; i < 20 && !g_got; i++) begin
      if (data_valid) begin
        g_got = 1'b1; g_cnt = rd_count; g_ov = rd_ovfl; g_fine = rd_fine; g_dp = rd_dp;
      end
      @(negedge clk);
    end
    check("R4 data_valid seen", 32'(g_got), 32'd1);
  endtask

  task automatic sample_read();
    send(1'b0, ME, 4'd1);
    idle(3);
    send(1'b0, ME, 4'd2);
    wait_dv();
  endtask

  task automatic pulse(logic u, logic d);
    up_in = u; dn_in = d;
    idle(2);
    up_in = 1'b0; dn_in = 1'b0;
    idle(3);
  endtask

  task automatic load(logic [CW-1:0] v, logic [3:0] t, logic arm);
    if (arm) send(1'b0, ME, 4'd3);
    dest_in = v; tol_in = t; dav = 1'b1;
    idle(2);
    dav = 1'b0;
    idle(3);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(3); rst = 1'b0; idle(1);
    check("R2 data_valid after reset", 32'(data_valid), 0);
    check("R2 diff_out after reset", 32'(diff_out), 0);
    check("R2 rd_count after reset", 32'(rd_count), 0);
    sample_read();
    check("R2 preset count", 32'(g_cnt), 160);
    check("R2 wrap flag clear", 32'(g_ov), 0);
    check("R4 coarse flag", 32'(g_fine), 0);
    check("R4 coarse point code", 32'(g_dp), 1);
  endtask

  task automatic t_counting();
    pulse(1, 0); pulse(1, 0); pulse(1, 0); pulse(0, 1); pulse(1, 1); pulse(1, 1);
    sample_read();
    check("R10 up/down with cancel", 32'(g_cnt), 162);
  endtask

  task automatic t_address();
    pulse(1, 0);                         // count 163
    send(1'b0, 3'd5, 4'd0); idle(2);     // foreign clear
    send(1'b0, ME, 4'd5); send(1'b0, ME, 4'd6); idle(2);
    send(1'b0, 3'd5, 4'd1); idle(3);     // foreign sample
    send(1'b0, ME, 4'd2); wait_dv();
    check("R1 foreign sample ignored", 32'(g_cnt), 162);
    sample_read();
    check("R1 foreign clear and no-ops ignored", 32'(g_cnt), 163);
  endtask

  task automatic t_broadcast();
    pulse(1, 0);                         // 164
    send(1'b1, 3'd7, 4'd1); idle(3);
    send(1'b0, ME, 4'd2); wait_dv();
    check("R11 broadcast sample", 32'(g_cnt), 164);
    send(1'b1, 3'd4, 4'd0); idle(2);
    sample_read();
    check("R11 broadcast clear", 32'(g_cnt), 160);
  endtask

  task automatic t_rate_down();
    send(1'b0, ME, 4'd4);
    for (int i = 0; i < 8; i++) begin
      up_in = i[0];
      @(negedge clk);
    end
    up_in = 1'b0;
    send(1'b0, ME, 4'd1); idle(3);
    send(1'b0, ME, 4'd2); wait_dv();
    check("R6 down rate, inputs ignored", 32'(g_cnt), 155);
    send(1'b0, ME, 4'd0); idle(10);
    sample_read();
    check("R2 self-test aborted by clear", 32'(g_cnt), 160);
  endtask

  task automatic t_window();
    send(1'b0, ME, 4'd7);
    send(1'b0, ME, 4'd1);
    send(1'b0, ME, 4'd2);
    wait_dv();
    check("R3 R4 capture slips past step, read waits", 32'(g_cnt), 161);
    send(1'b0, ME, 4'd0); idle(2);
  endtask

  task automatic t_wrap_up();
    send(1'b0, ME, 4'd7);
    idle(4200);
    pulse(1, 0);
    sample_read();
    check("R7 stops after upward wrap", 32'(g_cnt), 32'h801);
    check("R8 wrap flag sticky", 32'(g_ov), 1);
    send(1'b0, ME, 4'd0); idle(2);
    sample_read();
    check("R8 wrap flag cleared", 32'(g_ov), 0);
  endtask

  task automatic t_wrap_down();
    send(1'b0, ME, 4'd4);
    idle(4800);
    sample_read();
    check("R6 stops after downward wrap", 32'(g_cnt), 32'h7FF);
    check("R8 wrap flag on downward wrap", 32'(g_ov), 1);
    send(1'b0, ME, 4'd0); idle(2);
  endtask

  task automatic t_diff();
    check("R9 null before load", 32'(diff_out), 0);
    load(12'd0, 4'd0, 1'b0);
    check("R5 unarmed strobe ignored", 32'(diff_out), 0);
    load(12'd150, 4'd9, 1'b1);
    check("R9 outside tolerance", 32'(diff_out), 1);
    load(12'd155, 4'd5, 1'b1);
    check("R9 at tolerance edge", 32'(diff_out), 0);
    load(12'd165, 4'd4, 1'b1);
    check("R9 outside on negative side", 32'(diff_out), 1);
    load(12'd160, 4'd0, 1'b1);
    check("R9 exact match", 32'(diff_out), 0);
    load(12'd0, 4'd0, 1'b0);
    check("R5 strobe after load ignored", 32'(diff_out), 0);
    load(12'd0, 4'd0, 1'b1);
    check("R5 armed load", 32'(diff_out), 1);
    send(1'b0, ME, 4'd0); idle(3);
    check("R2 clear forces null", 32'(diff_out), 0);
    res_sel = 1'b1;
    sample_read();
    check("R4 fine flag", 32'(g_fine), 1);
    check("R4 fine point code", 32'(g_dp), 2);
    res_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_counting();
    t_address();
    t_broadcast();
    t_rate_down();
    t_window();
    t_wrap_up();
    t_wrap_down();
    t_diff();
    finish_up();
  end
endmodule